// File: doc/BRIEF.md
# Redirecting Interrupt Router

This block collects a set of interrupt request lines and turns them, one at a time, into vectored requests for a processor. Each input line has its own redirection entry. The entry holds the vector to report, a trigger mode (edge or level), a mask bit, a stored delivery-mode field, a destination byte and a read-only in-service flag. The in-service flag records that a level interrupt has been taken and that its end-of-interrupt notice is still owed. Software reaches every register through an indirect window. It first writes a register index, then reads or writes a 32-bit data word at that index. Three global registers sit next to the entries: an identifier, a fixed version word and an arbitration word that follows the identifier.

The processor side sees a valid/ready handshake that carries the vector and a flag giving the trigger mode of the source. An end-of-interrupt notice carries a vector. It releases every level entry programmed with that vector, so a line that is still high is offered again. The output sequencer has two states. In `ST_IDLE` nothing is offered. The transition *grab* happens when any unmasked line is requesting: the lowest-numbered one is latched and the sequencer moves to `ST_OFFER`. In `ST_OFFER` the latched vector is driven with `out_valid` high. The sequencer holds there while `out_ready` is low. The transition *take* happens on `out_ready`: the source is consumed (its edge is cleared, or its level flag is set) and the sequencer returns to `ST_IDLE`.

Top module: `intr_router`

## Requirements
- R1: After reset `out_valid` is 0, the identifier reads 0, and every redirection low word reads 0x0001_0000 (masked, edge, vector 0, flag clear).
- R2: Index 0x01 always reads {8'h00, N_LINES-1, 8'h00, 8'h11}, and writes to it change nothing.
- R3: At index 0x00 only bits 27:24 can be written. Writing the bitwise inverse of the current value changes exactly those four bits.
- R4: Index 0x02 reads bits 27:24 as last written to index 0x00, with all other bits zero. Writes to index 0x02 are ignored.
- R5: Line n's low word is at index 0x10+2n: vector in bits 7:0, delivery mode in bits 10:8, in-service flag in bit 14 (read-only), trigger in bit 15 (1 = level), mask in bit 16, other bits zero. The high word is at 0x11+2n and keeps only bits 31:24.
- R6: An unmasked edge line delivers exactly once per low-to-high transition. Holding it high afterwards delivers nothing more.
- R7: An unmasked, asserted level line is delivered once and sets bit 14. It is not delivered again until an EOI with its vector arrives. If the line is still high at that EOI, it is delivered again.
- R8: Pulses on a level line between delivery and EOI are merged into that one delivery. An EOI with a different vector leaves bit 14 set.
- R9: A rising edge seen while an edge entry is masked is dropped. Unmasking does not replay it, and a later edge is delivered.
- R10: A level line that is high while masked is delivered once the mask clears. Masking, then EOI, then unmasking while the line stays high gives one more delivery.
- R11: Among requesting lines the lowest-numbered is offered first. `out_level` equals the trigger bit of the offered entry.
- R12: While `out_valid` is high and `out_ready` low, `out_valid`, `out_vector` and `out_level` hold. After a cycle with both high, `out_valid` is low for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Load the register index |
| idx_wdata | input | 8 | New register index |
| win_we | input | 1 | Write the register at the current index |
| win_wdata | input | 32 | Data for a window write |
| win_rdata | output | 32 | Register at the current index (combinational) |
| irq_in | input | N_LINES | Interrupt request lines, active high |
| out_valid | output | 1 | A vectored interrupt is offered |
| out_ready | input | 1 | Processor takes the offered interrupt |
| out_vector | output | 8 | Vector of the offered interrupt |
| out_level | output | 1 | Offered source is level-triggered |
| eoi_valid | input | 1 | End-of-interrupt notice |
| eoi_vector | input | 8 | Vector named by the notice |

## Verification
The checks take for granted that `irq_in` is synchronous to `clk` and that software does not change the trigger mode of an entry while its source is on offer. The checks on the offer also assume that `eoi_vector` only names vectors that have been delivered. The bench drives every input on the falling edge. It reprograms an entry only while nothing is offered, and it sends end-of-interrupt notices only after the matching take or with a deliberately unused vector.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        trig_e      trig;
        logic [2:0] dmode;
        logic [7:0] vec;
    } redir_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } offer_state_e;

    localparam logic [7:0] IDX_ID    = 8'h00;
    localparam logic [7:0] IDX_VER   = 8'h01;
    localparam logic [7:0] IDX_ARB   = 8'h02;
    localparam logic [7:0] IDX_ENTRY = 8'h10;
    localparam logic [7:0] VER_CODE  = 8'h11;

endpackage

// File: rtl/intr_line_ctl.sv
module intr_line_ctl
    import intr_router_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   irq,
    input  redir_t cfg,
    input  logic   take,
    input  logic   eoi_hit,
    output logic   req,
    output logic   rirr
);
    logic irq_q;
    logic edge_pend_q;
    logic rirr_q;
    logic rise;

    assign rise = irq & ~irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q       <= 1'b0;
            edge_pend_q <= 1'b0;
            rirr_q      <= 1'b0;
        end else begin
            irq_q <= irq;
            if (cfg.trig == TRIG_EDGE) begin
                rirr_q <= 1'b0;
                if (rise && !cfg.mask)
                    edge_pend_q <= 1'b1;
                else if (take)
                    edge_pend_q <= 1'b0;
            end else begin
                edge_pend_q <= 1'b0;
                if (take)
                    rirr_q <= 1'b1;
                else if (eoi_hit)
                    rirr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (cfg.trig == TRIG_EDGE)
            req = edge_pend_q & ~cfg.mask;
        else
            req = irq & ~cfg.mask & ~rirr_q;
    end

    assign rirr = rirr_q;

endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
    parameter int N_LINES = 24,
    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] req,
    output logic               any,
    output logic [LW-1:0]      idx
);
    always_comb begin
        idx = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (req[i])
                idx = LW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/intr_router.sv
module intr_router
    import intr_router_pkg::*;
#(
    parameter int N_LINES = 24,
    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int IDX_END = 16 + 2 * N_LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_we,
    input  logic [7:0]         idx_wdata,
    input  logic               win_we,
    input  logic [31:0]        win_wdata,
    output logic [31:0]        win_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_vector,
    output logic               out_level,
    input  logic               eoi_valid,
    input  logic [7:0]         eoi_vector
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(N_LINES - 1), 8'h00, VER_CODE};

    logic [7:0]   idx_q;
    logic [3:0]   id_q;
    logic [3:0]   arb_q;
    redir_t       cfg [N_LINES];
    logic [N_LINES-1:0] req;
    logic [N_LINES-1:0] rirr;
    logic         ent_hit;
    logic         ent_hi;
    logic [LW-1:0] ent_sel;
    logic [7:0]   ent_off;
    logic         any_req;
    logic [LW-1:0] pick_idx;

    offer_state_e state_q, state_d;
    logic [LW-1:0] line_q;
    logic [7:0]   vec_q;
    logic         lvl_q;
    logic         take;

    // ---------------- register window ----------------
    always_comb begin
        ent_off = idx_q - IDX_ENTRY;
        ent_hit = (idx_q >= IDX_ENTRY) && (32'(idx_q) < IDX_END);
        ent_hi  = ent_off[0];
        ent_sel = LW'(ent_off[7:1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            id_q  <= '0;
            arb_q <= '0;
            for (int i = 0; i < N_LINES; i++) begin
                cfg[i] <= '{dest: 8'h00, mask: 1'b1, trig: TRIG_EDGE,
                            dmode: 3'b000, vec: 8'h00};
            end
        end else begin
            if (idx_we)
                idx_q <= idx_wdata;
            if (win_we) begin
                if (idx_q == IDX_ID) begin
                    id_q  <= win_wdata[27:24];
                    arb_q <= win_wdata[27:24];
                end else if (ent_hit) begin
                    if (ent_hi) begin
                        cfg[ent_sel].dest <= win_wdata[31:24];
                    end else begin
                        cfg[ent_sel].vec   <= win_wdata[7:0];
                        cfg[ent_sel].dmode <= win_wdata[10:8];
                        cfg[ent_sel].trig  <= trig_e'(win_wdata[15]);
                        cfg[ent_sel].mask  <= win_wdata[16];
                    end
                end
            end
        end
    end

    always_comb begin
        win_rdata = '0;
        if (idx_q == IDX_ID)
            win_rdata = {4'b0000, id_q, 24'h000000};
        else if (idx_q == IDX_VER)
            win_rdata = VER_WORD;
        else if (idx_q == IDX_ARB)
            win_rdata = {4'b0000, arb_q, 24'h000000};
        else if (ent_hit) begin
            if (ent_hi)
                win_rdata = {cfg[ent_sel].dest, 24'h000000};
            else
                win_rdata = {15'h0000, cfg[ent_sel].mask, cfg[ent_sel].trig,
                             rirr[ent_sel], 3'b000, cfg[ent_sel].dmode,
                             cfg[ent_sel].vec};
        end
    end

    // ---------------- per-line request logic ----------------
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        intr_line_ctl u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq     (irq_in[g]),
            .cfg     (cfg[g]),
            .take    (take && (line_q == LW'(g))),
            .eoi_hit (eoi_valid && (eoi_vector == cfg[g].vec)),
            .req     (req[g]),
            .rirr    (rirr[g])
        );
    end

    intr_pick #(.N_LINES(N_LINES)) u_pick (
        .req (req),
        .any (any_req),
        .idx (pick_idx)
    );

    // ---------------- output sequencer ----------------
    assign take = (state_q == ST_OFFER) && out_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_req) state_d = ST_OFFER;
            ST_OFFER: if (out_ready) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            vec_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && any_req) begin
                line_q <= pick_idx;
                vec_q  <= cfg[pick_idx].vec;
                lvl_q  <= cfg[pick_idx].trig == TRIG_LEVEL;
            end
        end
    end

    always_comb begin
        out_valid  = 1'b0;
        out_vector = vec_q;
        out_level  = lvl_q;
        unique case (state_q)
            ST_IDLE:  out_valid = 1'b0;
            ST_OFFER: out_valid = 1'b1;
        endcase
    end

endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk #(
    parameter int N_LINES = 24,
    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               out_valid,
    input logic               out_ready,
    input logic [7:0]         out_vector,
    input logic               out_level,
    input logic [N_LINES-1:0] req,
    input logic [N_LINES-1:0] rirr,
    input logic [LW-1:0]      line_sel
);
    logic [N_LINES-1:0] req_prev;
    logic [N_LINES-1:0] below_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) req_prev <= '0;
        else        req_prev <= req;
    end

    assign below_sel = (N_LINES'(1) << line_sel) - N_LINES'(1);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_vector) && $stable(out_level));

    p_gap_after_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid);

    p_no_double_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_level |-> !rirr[line_sel]);

    p_lowest_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> req_prev[line_sel] && ((req_prev & below_sel) == '0));

endmodule

bind intr_router intr_router_chk #(.N_LINES(N_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_vector (out_vector),
    .out_level  (out_level),
    .req        (req),
    .rirr       (rirr),
    .line_sel   (line_q)
);

// File: tb/tb_intr_router.sv
module tb_intr_router;
    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          idx_we = 1'b0;
    logic [7:0]    idx_wdata = '0;
    logic          win_we = 1'b0;
    logic [31:0]   win_wdata = '0;
    logic [31:0]   win_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_vector;
    logic          out_level;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intr_router #(.N_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .win_we(win_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .irq_in(irq_in), .out_valid(out_valid), .out_ready(out_ready),
        .out_vector(out_vector), .out_level(out_level),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [7:0] i, output logic [31:0] d);
        @(negedge clk); idx_we = 1'b1; idx_wdata = i;
        @(negedge clk); idx_we = 1'b0;
        d = win_rdata;
    endtask

    task automatic wr_reg(input logic [7:0] i, input logic [31:0] d);
        @(negedge clk); idx_we = 1'b1; idx_wdata = i;
        @(negedge clk); idx_we = 1'b0; win_we = 1'b1; win_wdata = d;
        @(negedge clk); win_we = 1'b0;
    endtask

    function automatic logic [7:0] lo_idx(input int line);
        return 8'(16 + 2 * line);
    endfunction

    task automatic set_entry(input int line, input logic [7:0] vec, input bit lvl, input bit msk);
        wr_reg(lo_idx(line), {15'h0, msk, lvl, 7'h0, vec});
    endtask

    task automatic drive(input int line, input bit v);
        @(negedge clk); irq_in[line] = v;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic wait_valid(input string tag);
        bit seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(seen, tag, 32'(seen), 32'd1);
    endtask

    task automatic wait_offer(input logic [7:0] vec, input bit lvl, input string tag);
        bit seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(seen, tag, 32'(seen), 32'd1);
        if (seen) begin
            chk(out_vector == vec && out_level == lvl, tag,
                {23'h0, out_level, out_vector}, {23'h0, lvl, vec});
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        bit hit = 1'b0;
        logic [7:0] v = '0;
        for (int k = 0; k < cycles && !hit; k++) begin
            @(negedge clk);
            if (out_valid) begin hit = 1'b1; v = out_vector; end
        end
        chk(!hit, tag, {24'h0, v}, 32'h0);
        if (hit) begin
            out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_r1();
        logic [31:0] d;
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        rd_reg(lo_idx(14), d);
        chk(d == 32'h0001_0000, "R1 entry reset value", d, 32'h0001_0000);
        rd_reg(8'h00, d);
        chk(d == 32'h0, "R1 identifier reset", d, 32'h0);
    endtask

    task automatic t_version_r2();
        logic [31:0] d, e;
        e = {8'h00, 8'(N - 1), 8'h00, 8'h11};
        rd_reg(8'h01, d);
        chk(d == e, "R2 version value", d, e);
        wr_reg(8'h01, ~d);
        rd_reg(8'h01, d);
        chk(d == e, "R2 version read-only", d, e);
    endtask

    task automatic t_id_r3();
        logic [31:0] a, b;
        rd_reg(8'h00, a);
        wr_reg(8'h00, ~a);
        rd_reg(8'h00, b);
        chk((a ^ b) == 32'h0F00_0000, "R3 identifier writable bits", a ^ b, 32'h0F00_0000);
    endtask

    task automatic t_arb_r4();
        logic [31:0] d;
        wr_reg(8'h00, 32'hFA55_AA55);
        rd_reg(8'h02, d);
        chk(d == 32'h0A00_0000, "R4 arbitration follows identifier", d, 32'h0A00_0000);
        wr_reg(8'h02, 32'h0);
        rd_reg(8'h02, d);
        chk(d == 32'h0A00_0000, "R4 arbitration write ignored", d, 32'h0A00_0000);
    endtask

    task automatic t_layout_r5();
        logic [31:0] d;
        wr_reg(lo_idx(5), 32'hFFFE_C5A7);
        rd_reg(lo_idx(5), d);
        chk(d == 32'h0000_85A7, "R5 low word fields", d, 32'h0000_85A7);
        wr_reg(lo_idx(5) + 8'd1, 32'hFFFF_FFFF);
        rd_reg(lo_idx(5) + 8'd1, d);
        chk(d == 32'hFF00_0000, "R5 high word", d, 32'hFF00_0000);
        set_entry(5, 8'h00, 1'b0, 1'b1);
        wr_reg(lo_idx(5) + 8'd1, 32'h0);
    endtask

    task automatic t_edge_r6();
        set_entry(14, 8'h76, 1'b0, 1'b0);
        drive(14, 1'b1);
        wait_offer(8'h76, 1'b0, "R6 edge delivered");
        expect_quiet(20, "R6 held level no repeat");
        drive(14, 1'b0);
        expect_quiet(5, "R6 falling edge silent");
        drive(14, 1'b1);
        wait_offer(8'h76, 1'b0, "R6 second edge delivered");
        drive(14, 1'b0);
        set_entry(14, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_level_r7();
        logic [31:0] d;
        set_entry(14, 8'h77, 1'b1, 1'b0);
        drive(14, 1'b1);
        wait_offer(8'h77, 1'b1, "R7 level delivered");
        expect_quiet(20, "R7 no repeat before EOI");
        rd_reg(lo_idx(14), d);
        chk(d[14] == 1'b1, "R7 in-service flag set", d, d | 32'h4000);
        send_eoi(8'h77);
        wait_offer(8'h77, 1'b1, "R7 redelivered after EOI");
        drive(14, 1'b0);
        send_eoi(8'h77);
        expect_quiet(10, "R7 quiet after final EOI");
        rd_reg(lo_idx(14), d);
        chk(d[14] == 1'b0, "R7 in-service flag cleared", d, d & ~32'h4000);
    endtask

    task automatic t_coalesce_r8();
        logic [31:0] d;
        set_entry(14, 8'h98, 1'b1, 1'b0);
        drive(14, 1'b1);
        wait_offer(8'h98, 1'b1, "R8 first delivery");
        for (int k = 0; k < 3; k++) begin
            drive(14, 1'b0);
            drive(14, 1'b1);
        end
        expect_quiet(10, "R8 pulses coalesced");
        send_eoi(8'h55);
        expect_quiet(20, "R8 foreign EOI no release");
        rd_reg(lo_idx(14), d);
        chk(d[14] == 1'b1, "R8 flag kept on foreign EOI", d, d | 32'h4000);
        drive(14, 1'b0);
        send_eoi(8'h98);
        expect_quiet(20, "R8 no extra delivery");
        set_entry(14, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_mask_edge_r9();
        set_entry(14, 8'h81, 1'b0, 1'b1);
        drive(14, 1'b1);
        drive(14, 1'b0);
        set_entry(14, 8'h81, 1'b0, 1'b0);
        expect_quiet(20, "R9 masked edge dropped");
        drive(14, 1'b1);
        wait_offer(8'h81, 1'b0, "R9 new edge delivered");
        drive(14, 1'b0);
        set_entry(14, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_mask_level_r10();
        set_entry(14, 8'h82, 1'b1, 1'b1);
        drive(14, 1'b1);
        expect_quiet(20, "R10 masked level held");
        set_entry(14, 8'h82, 1'b1, 1'b0);
        wait_offer(8'h82, 1'b1, "R10 delivered on unmask");
        set_entry(14, 8'h82, 1'b1, 1'b1);
        send_eoi(8'h82);
        expect_quiet(10, "R10 masked after EOI");
        set_entry(14, 8'h82, 1'b1, 1'b0);
        wait_offer(8'h82, 1'b1, "R10 redelivered after remask");
        drive(14, 1'b0);
        send_eoi(8'h82);
        set_entry(14, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_priority_r11();
        set_entry(20, 8'hA0, 1'b0, 1'b0);
        set_entry(9, 8'h90, 1'b0, 1'b0);
        set_entry(3, 8'h30, 1'b1, 1'b0);
        drive(20, 1'b1);
        wait_valid("R11 first offer present");
        drive(9, 1'b1);
        drive(3, 1'b1);
        repeat (4) @(negedge clk);
        wait_offer(8'hA0, 1'b0, "R11 held offer first");
        wait_offer(8'h30, 1'b1, "R11 lowest line next with level flag");
        wait_offer(8'h90, 1'b0, "R11 higher line last with edge flag");
        drive(3, 1'b0);
        drive(9, 1'b0);
        drive(20, 1'b0);
        send_eoi(8'h30);
        expect_quiet(10, "R11 nothing left");
        set_entry(20, 8'h00, 1'b0, 1'b1);
        set_entry(9, 8'h00, 1'b0, 1'b1);
        set_entry(3, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_hold_r12();
        bit ok = 1'b1;
        set_entry(14, 8'h44, 1'b0, 1'b0);
        drive(14, 1'b1);
        wait_valid("R12 offer present");
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!(out_valid && out_vector == 8'h44 && !out_level)) ok = 1'b0;
        end
        chk(ok, "R12 offer held while not ready", {23'h0, out_level, out_vector}, 32'h44);
        wait_offer(8'h44, 1'b0, "R12 taken");
        chk(out_valid == 1'b0, "R12 valid drops after take", 32'(out_valid), 32'd0);
        drive(14, 1'b0);
        set_entry(14, 8'h00, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_version_r2();
        t_id_r3();
        t_arb_r4();
        t_layout_r5();
        t_edge_r6();
        t_level_r7();
        t_coalesce_r8();
        t_mask_edge_r9();
        t_mask_level_r10();
        t_priority_r11();
        t_hold_r12();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd100000, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule